// File: doc/BRIEF.md
# Banked Memory Controller with Video Plane Window

This block sits between an 8-bit CPU and its local memories. It decodes every CPU read or write to one of five backing stores: a boot ROM that fills the lower half of the address space, a small disk-controller ROM that can cover one 1/16 page of that half, two RAM halves, and four video planes. The video planes are each a quarter of the space in size. Two mapping registers steer the decode. The first is loaded from a parallel-port output value under a mask. The second is loaded by any CPU I/O write to the block.

The video planes have a write-broadcast and read-merge window. When the window is open, one CPU write lands in every enabled plane at the same time. A read returns the bitwise AND of all enabled planes, which lets software fill or test several colour planes in one access.

The CPU address width is the parameter `AW`. With `AW = 16` the block decodes a full 64 KB map: the window sits at 0x8000–0xBFFF and the disk-controller page at 0x6000–0x6FFF. The default is `AW = 10`, which keeps the backing arrays small while preserving the same proportions. Both ROMs are written through a preload port, and a ROM that has never been preloaded reads as 0xFF. Reads take one cycle and writes take effect at the clock edge on which they are presented.

Top module: `banked_mem_ctrl`

## Requirements
- R1: After reset, map register A holds 0x0F and map register B holds 0x00. As a result the window is closed, the lower half reads the boot ROM, `rd_valid` is low, and `dsk_absent` is high.
- R2: On a clock edge where `pio_c_upd` is high, map register A takes `pio_c_data & pio_c_mask`. The new value governs accesses from the next cycle on, and register A is otherwise unchanged.
- R3: On a clock edge where `io_wr` is high, map register B takes `io_wdata`. Register B is otherwise unchanged.
- R4: When bit 4 of register A is 1, addresses with `cpu_addr[AW-1:AW-2] == 2'b10` form the video window. Within each plane, `cpu_addr[AW-3:0]` selects the byte.
- R5: A window write stores the byte into every plane n (n = 0..3) whose enable, bit n of register A, is 0. Planes whose enable bit is 1 are left unchanged.
- R6: A window read returns 0xFF ANDed with the byte of every enabled plane at that offset. With no plane enabled it returns 0xFF.
- R7: When bit 5 of register A is 1, the lower half (`cpu_addr[AW-1] == 0`) is RAM half 0 for both reads and writes.
- R8: When bit 5 of register A is 0, lower-half reads return the boot ROM byte at `cpu_addr[AW-2:0]`, and lower-half writes change no storage.
- R9: When bit 5 of register A is 0 and bit 0 of register B is 1, reads with `cpu_addr[AW-1:AW-4] == 6` return the disk ROM byte at `cpu_addr[AW-5:0]`.
- R10: Outside the window, the upper half (`cpu_addr[AW-1] == 1`) is RAM half 1 for both reads and writes, with the byte selected by `cpu_addr[AW-2:0]`.
- R11: A `pre_we` with `pre_sel = 0` writes the boot ROM at `pre_addr`. With `pre_sel = 1` it writes the disk ROM at `pre_addr[AW-5:0]`. A ROM with no preload since reset reads 0xFF.
- R12: `dsk_absent` is high after reset and goes low on the cycle after the first disk ROM preload.
- R13: A `cpu_rd` without `cpu_wr` gives `rd_valid` high, with the data on `rd_data`, in the next cycle. When `cpu_rd` and `cpu_wr` are both high, only the write is performed and `rd_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It is asserted asynchronously and must be released in step with `clk`. |
| cpu_addr | input | AW | CPU memory address |
| cpu_rd | input | 1 | CPU memory read request |
| cpu_wr | input | 1 | CPU memory write request |
| cpu_wdata | input | 8 | CPU write data |
| rd_data | output | 8 | Read data, valid while `rd_valid` is high |
| rd_valid | output | 1 | Read data strobe, one cycle after the request |
| io_wr | input | 1 | CPU I/O write strobe that loads map register B |
| io_wdata | input | 8 | CPU I/O write data |
| pio_c_upd | input | 1 | Parallel-port output update strobe |
| pio_c_data | input | 8 | Parallel-port output value |
| pio_c_mask | input | 8 | Mask applied to the parallel-port value |
| pre_we | input | 1 | ROM preload write strobe |
| pre_sel | input | 1 | Preload target: 0 for the boot ROM, 1 for the disk ROM |
| pre_addr | input | AW-1 | Preload byte address |
| pre_wdata | input | 8 | Preload data |
| dsk_absent | output | 1 | High until the disk ROM has been preloaded |

## Verification
The bench writes different bytes through different plane-enable patterns and then reads the same offset under other enable sets. A design that wrote only one plane, or that ORed the planes instead of ANDing them, shows the wrong merged byte. With every enable at 1 the read must be 0xFF rather than stale plane data.

A lower-half write made in ROM mode is followed by a read of that address in RAM mode. A design that let the write through leaves the new byte in RAM half 0 instead of the old one. Further checks read the disk page with register B bit 0 both clear and set, read a ROM that has never been preloaded, and issue a read and a write in the same cycle, which must not raise `rd_valid`.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  localparam int NPLANE   = 4;
  localparam int DW       = 8;
  localparam int A_WIN    = 4;
  localparam int A_RAMLO  = 5;
  localparam int DSK_PAGE = 6;

  typedef enum logic [2:0] {
    SRC_BOOT = 3'd0,
    SRC_DISK = 3'd1,
    SRC_RAM0 = 3'd2,
    SRC_RAM1 = 3'd3,
    SRC_VRAM = 3'd4
  } src_e;

endpackage

// File: rtl/mbc_store.sv
module mbc_store #(
  parameter int DAW = 9,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           we,
  input  logic [DAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic           re,
  input  logic [DAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);

  localparam int DEPTH = 1 << DAW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata_q <= mem[raddr];
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/mbc_maps.sv
module mbc_maps
  import mbc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pio_upd,
  input  logic [DW-1:0] pio_data,
  input  logic [DW-1:0] pio_mask,
  input  logic          io_wr,
  input  logic [DW-1:0] io_data,
  input  logic          pre_we,
  input  logic          pre_sel,
  output logic [DW-1:0] map_a,
  output logic [DW-1:0] map_b,
  output logic          boot_ok,
  output logic          disk_ok
);

  logic [DW-1:0] map_a_d, map_b_d;
  logic          boot_ok_d, disk_ok_d;

  always_comb begin
    map_a_d   = map_a;
    map_b_d   = map_b;
    boot_ok_d = boot_ok;
    disk_ok_d = disk_ok;
    if (pio_upd) begin
      map_a_d = pio_data & pio_mask;
    end
    if (io_wr) begin
      map_b_d = io_data;
    end
    if (pre_we && !pre_sel) begin
      boot_ok_d = 1'b1;
    end
    if (pre_we && pre_sel) begin
      disk_ok_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_a   <= 8'h0F;
      map_b   <= 8'h00;
      boot_ok <= 1'b0;
      disk_ok <= 1'b0;
    end else begin
      map_a   <= map_a_d;
      map_b   <= map_b_d;
      boot_ok <= boot_ok_d;
      disk_ok <= disk_ok_d;
    end
  end

endmodule

// File: rtl/mbc_decode.sv
module mbc_decode
  import mbc_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [AW-1:0]     addr,
  input  logic              wr,
  input  logic [5:0]        map_a,
  input  logic              disk_map,
  output src_e              src,
  output logic [NPLANE-1:0] pen,
  output logic              ram0_we,
  output logic              ram1_we,
  output logic [NPLANE-1:0] plane_we
);

  logic [3:0] page;
  logic       in_win;

  assign page   = addr[AW-1 -: 4];
  assign in_win = map_a[A_WIN] && (addr[AW-1:AW-2] == 2'b10);

  always_comb begin
    src      = SRC_BOOT;
    pen      = '0;
    ram0_we  = 1'b0;
    ram1_we  = 1'b0;
    plane_we = '0;
    if (in_win) begin
      src      = SRC_VRAM;
      pen      = ~map_a[NPLANE-1:0];
      plane_we = wr ? ~map_a[NPLANE-1:0] : '0;
    end else if (addr[AW-1]) begin
      src     = SRC_RAM1;
      ram1_we = wr;
    end else if (map_a[A_RAMLO]) begin
      src     = SRC_RAM0;
      ram0_we = wr;
    end else if (disk_map && (page == 4'(DSK_PAGE))) begin
      src = SRC_DISK;
    end
  end

endmodule

// File: rtl/banked_mem_ctrl.sv
module banked_mem_ctrl
  import mbc_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    rd_data,
  output logic          rd_valid,
  input  logic          io_wr,
  input  logic [7:0]    io_wdata,
  input  logic          pio_c_upd,
  input  logic [7:0]    pio_c_data,
  input  logic [7:0]    pio_c_mask,
  input  logic          pre_we,
  input  logic          pre_sel,
  input  logic [AW-2:0] pre_addr,
  input  logic [7:0]    pre_wdata,
  output logic          dsk_absent
);

  localparam int HAW = AW - 1;
  localparam int PAW = AW - 2;
  localparam int DAW = AW - 4;

  logic [DW-1:0]     map_a_q, map_b_q;
  logic              boot_ok, disk_ok;
  src_e              dec_src;
  logic [NPLANE-1:0] dec_pen;
  logic              ram0_we, ram1_we;
  logic [NPLANE-1:0] plane_we;
  logic              rd_go;

  src_e              src_q, src_d;
  logic [NPLANE-1:0] pen_q, pen_d;
  logic              rvld_q, rvld_d;

  logic [DW-1:0]     boot_q, disk_q, ram0_q, ram1_q;
  logic [DW-1:0]     plane_q [NPLANE];
  logic [DW-1:0]     merge;

  assign rd_go = cpu_rd && !cpu_wr;

  mbc_maps u_maps (
    .clk      (clk),
    .rst_n    (rst_n),
    .pio_upd  (pio_c_upd),
    .pio_data (pio_c_data),
    .pio_mask (pio_c_mask),
    .io_wr    (io_wr),
    .io_data  (io_wdata),
    .pre_we   (pre_we),
    .pre_sel  (pre_sel),
    .map_a    (map_a_q),
    .map_b    (map_b_q),
    .boot_ok  (boot_ok),
    .disk_ok  (disk_ok)
  );

  mbc_decode #(.AW(AW)) u_dec (
    .addr     (cpu_addr),
    .wr       (cpu_wr),
    .map_a    (map_a_q[5:0]),
    .disk_map (map_b_q[0]),
    .src      (dec_src),
    .pen      (dec_pen),
    .ram0_we  (ram0_we),
    .ram1_we  (ram1_we),
    .plane_we (plane_we)
  );

  mbc_store #(.DAW(HAW), .DW(DW)) u_boot (
    .clk   (clk),
    .we    (pre_we && !pre_sel),
    .waddr (pre_addr),
    .wdata (pre_wdata),
    .re    (rd_go),
    .raddr (cpu_addr[HAW-1:0]),
    .rdata (boot_q)
  );

  mbc_store #(.DAW(DAW), .DW(DW)) u_disk (
    .clk   (clk),
    .we    (pre_we && pre_sel),
    .waddr (pre_addr[DAW-1:0]),
    .wdata (pre_wdata),
    .re    (rd_go),
    .raddr (cpu_addr[DAW-1:0]),
    .rdata (disk_q)
  );

  mbc_store #(.DAW(HAW), .DW(DW)) u_ram0 (
    .clk   (clk),
    .we    (ram0_we),
    .waddr (cpu_addr[HAW-1:0]),
    .wdata (cpu_wdata),
    .re    (rd_go),
    .raddr (cpu_addr[HAW-1:0]),
    .rdata (ram0_q)
  );

  mbc_store #(.DAW(HAW), .DW(DW)) u_ram1 (
    .clk   (clk),
    .we    (ram1_we),
    .waddr (cpu_addr[HAW-1:0]),
    .wdata (cpu_wdata),
    .re    (rd_go),
    .raddr (cpu_addr[HAW-1:0]),
    .rdata (ram1_q)
  );

  for (genvar gi = 0; gi < NPLANE; gi++) begin : g_plane
    mbc_store #(.DAW(PAW), .DW(DW)) u_plane (
      .clk   (clk),
      .we    (plane_we[gi]),
      .waddr (cpu_addr[PAW-1:0]),
      .wdata (cpu_wdata),
      .re    (rd_go),
      .raddr (cpu_addr[PAW-1:0]),
      .rdata (plane_q[gi])
    );
  end

  always_comb begin
    src_d  = src_q;
    pen_d  = pen_q;
    rvld_d = rd_go;
    if (rd_go) begin
      src_d = dec_src;
      pen_d = dec_pen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_BOOT;
      pen_q  <= '0;
      rvld_q <= 1'b0;
    end else begin
      src_q  <= src_d;
      pen_q  <= pen_d;
      rvld_q <= rvld_d;
    end
  end

  always_comb begin
    merge = 8'hFF;
    for (int i = 0; i < NPLANE; i++) begin
      if (pen_q[i]) begin
        merge = merge & plane_q[i];
      end
    end
  end

  always_comb begin
    case (src_q)
      SRC_BOOT: rd_data = boot_ok ? boot_q : 8'hFF;
      SRC_DISK: rd_data = disk_ok ? disk_q : 8'hFF;
      SRC_RAM0: rd_data = ram0_q;
      SRC_RAM1: rd_data = ram1_q;
      SRC_VRAM: rd_data = merge;
      default:  rd_data = 8'hFF;
    endcase
  end

  assign rd_valid   = rvld_q;
  assign dsk_absent = !disk_ok;

endmodule

// File: rtl/banked_mem_ctrl_chk.sv
module banked_mem_ctrl_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_rd,
  input logic          cpu_wr,
  input logic [7:0]    rd_data,
  input logic          rd_valid,
  input logic          io_wr,
  input logic [7:0]    io_wdata,
  input logic          pio_c_upd,
  input logic [7:0]    pio_c_data,
  input logic [7:0]    pio_c_mask,
  input logic          pre_we,
  input logic          pre_sel,
  input logic          dsk_absent,
  input logic [7:0]    map_a,
  input logic [7:0]    map_b,
  input logic          ram0_we
);

  AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr) |=> rd_valid) else $error("rd_valid missing"); // R13

  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cpu_rd && !cpu_wr)) else $error("stray rd_valid"); // R13

  AST_MAPA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pio_c_upd |=> (map_a == $past(pio_c_data & pio_c_mask))) else $error("map A load"); // R2

  AST_MAPA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pio_c_upd |=> $stable(map_a)) else $error("map A drift"); // R2

  AST_MAPB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |=> (map_b == $past(io_wdata))) else $error("map B load"); // R3

  AST_ROM_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !map_a[5] && !cpu_addr[AW-1]) |-> !ram0_we) else $error("ROM-mode write reached RAM"); // R8

  AST_EMPTY_WINDOW_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(cpu_rd && !cpu_wr && map_a[4] && (map_a[3:0] == 4'hF)
                       && (cpu_addr[AW-1:AW-2] == 2'b10)))
    |-> (rd_data == 8'hFF)) else $error("empty plane set not 0xFF"); // R6

  AST_DISK_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_we && pre_sel) |=> !dsk_absent) else $error("dsk_absent stuck"); // R12

endmodule

bind banked_mem_ctrl banked_mem_ctrl_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_addr   (cpu_addr),
  .cpu_rd     (cpu_rd),
  .cpu_wr     (cpu_wr),
  .rd_data    (rd_data),
  .rd_valid   (rd_valid),
  .io_wr      (io_wr),
  .io_wdata   (io_wdata),
  .pio_c_upd  (pio_c_upd),
  .pio_c_data (pio_c_data),
  .pio_c_mask (pio_c_mask),
  .pre_we     (pre_we),
  .pre_sel    (pre_sel),
  .dsk_absent (dsk_absent),
  .map_a      (map_a_q),
  .map_b      (map_b_q),
  .ram0_we    (ram0_we)
);

// File: tb/banked_mem_ctrl_bench.sv
module banked_mem_ctrl_bench;

  localparam int AW    = 10;
  localparam int HALF  = 1 << (AW - 1);
  localparam int PLANE = 1 << (AW - 2);
  localparam int PAGE  = 1 << (AW - 4);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] cpu_addr;
  logic          cpu_rd, cpu_wr;
  logic [7:0]    cpu_wdata;
  logic [7:0]    rd_data;
  logic          rd_valid;
  logic          io_wr;
  logic [7:0]    io_wdata;
  logic          pio_c_upd;
  logic [7:0]    pio_c_data, pio_c_mask;
  logic          pre_we, pre_sel;
  logic [AW-2:0] pre_addr;
  logic [7:0]    pre_wdata;
  logic          dsk_absent;

  always #2 clk = ~clk;

  banked_mem_ctrl #(.AW(AW)) u_banked_mem_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .rd_data(rd_data), .rd_valid(rd_valid), .io_wr(io_wr),
    .io_wdata(io_wdata), .pio_c_upd(pio_c_upd), .pio_c_data(pio_c_data),
    .pio_c_mask(pio_c_mask), .pre_we(pre_we), .pre_sel(pre_sel), .pre_addr(pre_addr),
    .pre_wdata(pre_wdata), .dsk_absent(dsk_absent)
  );

  // Reference model: -1 marks a byte never written
  int   boot_m [HALF];
  int   disk_m [PAGE];
  int   ram0_m [HALF];
  int   ram1_m [HALF];
  int   vram_m [4][PLANE];
  bit   boot_ok_m, disk_ok_m;
  logic [7:0] ma, mb;

  int    total = 0;
  int    bad   = 0;
  bit    exp_vld;
  int    exp_data;
  string exp_tag;

  function automatic bit in_window(int a);
    return ma[4] && ((a >> (AW - 2)) == 2);
  endfunction

  function automatic int ref_read(int a);
    int v;
    if (in_window(a)) begin
      v = 255;
      for (int p = 0; p < 4; p++) begin
        if (!ma[p]) begin
          if (vram_m[p][a % PLANE] < 0) return -1;
          v = v & vram_m[p][a % PLANE];
        end
      end
      return v;
    end
    if (a >= HALF) return ram1_m[a - HALF];
    if (ma[5]) return ram0_m[a];
    if (mb[0] && ((a / PAGE) == 6)) return disk_ok_m ? disk_m[a % PAGE] : 255;
    return boot_ok_m ? boot_m[a] : 255;
  endfunction

  function automatic void ref_write(int a, int d);
    if (in_window(a)) begin
      for (int p = 0; p < 4; p++) if (!ma[p]) vram_m[p][a % PLANE] = d;
    end else if (a >= HALF) begin
      ram1_m[a - HALF] = d;
    end else if (ma[5]) begin
      ram0_m[a] = d;
    end
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cpu_rd = 0; cpu_wr = 0; io_wr = 0; pio_c_upd = 0; pre_we = 0;
  endtask

  // Called at a negedge with inputs set; model advances, outputs checked next negedge
  task automatic apply(string tag);
    exp_vld = cpu_rd && !cpu_wr;
    exp_tag = tag;
    if (exp_vld) exp_data = ref_read(int'(cpu_addr));
    if (cpu_wr) ref_write(int'(cpu_addr), int'(cpu_wdata));
    if (pio_c_upd) ma = pio_c_data & pio_c_mask;
    if (io_wr) mb = io_wdata;
    if (pre_we) begin
      if (!pre_sel) begin boot_m[pre_addr] = pre_wdata; boot_ok_m = 1; end
      else begin disk_m[int'(pre_addr) % PAGE] = pre_wdata; disk_ok_m = 1; end
    end
    @(posedge clk);
    @(negedge clk);
    check({exp_tag, " R13 rd_valid"}, int'(rd_valid), int'(exp_vld));
    if (exp_vld && exp_data >= 0) check({exp_tag, " rd_data"}, int'(rd_data), exp_data);
    check("R12 dsk_absent", int'(dsk_absent), int'(!disk_ok_m));
    idle();
  endtask

  task automatic wr(int a, int d, string tag);
    cpu_addr = AW'(a); cpu_wdata = 8'(d); cpu_wr = 1; apply(tag);
  endtask

  task automatic rd(int a, string tag);
    cpu_addr = AW'(a); cpu_rd = 1; apply(tag);
  endtask

  task automatic set_a(int d, int m, string tag);
    pio_c_data = 8'(d); pio_c_mask = 8'(m); pio_c_upd = 1; apply(tag);
  endtask

  task automatic set_b(int d, string tag);
    io_wdata = 8'(d); io_wr = 1; apply(tag);
  endtask

  task automatic pre(bit s, int a, int d);
    pre_sel = s; pre_addr = (AW-1)'(a); pre_wdata = 8'(d); pre_we = 1; apply("R11 preload");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R13 actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < HALF; i++) begin boot_m[i] = -1; ram0_m[i] = -1; ram1_m[i] = -1; end
    for (int i = 0; i < PAGE; i++) disk_m[i] = -1;
    for (int p = 0; p < 4; p++) for (int i = 0; i < PLANE; i++) vram_m[p][i] = -1;
    boot_ok_m = 0; disk_ok_m = 0; ma = 8'h0F; mb = 8'h00; exp_vld = 0;
    cpu_addr = '0; cpu_wdata = '0; io_wdata = '0; pio_c_data = '0; pio_c_mask = '0;
    pre_sel = 0; pre_addr = '0; pre_wdata = '0;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 rd_valid in reset", int'(rd_valid), 0);
    check("R1 dsk_absent in reset", int'(dsk_absent), 1);
    rst_n = 1;
    @(negedge clk);

    // R1/R11: unloaded boot ROM reads 0xFF; window closed after reset
    rd(5, "R1 R11 empty boot");
    wr(520, 8'h6B, "R1 window closed write");
    rd(520, "R1 R10 window closed read");

    // R11/R12: preload both ROMs
    for (int i = 0; i < 16; i++) pre(0, i, 8'hA0 + i);
    for (int i = 0; i < 16; i++) pre(0, 384 + i, 8'h30 + i);
    for (int i = 0; i < 16; i++) pre(1, i, 8'hC0 + i);
    rd(3, "R8 boot read");
    rd(386, "R9 disk page with B0 clear");
    set_b(8'h01, "R3 load B");
    rd(386, "R9 disk page with B0 set");
    rd(3, "R9 boot outside disk page");

    // R7/R8: ROM-mode write dropped
    set_a(8'h2F, 8'hFF, "R2 RAM mode");
    wr(3, 8'hA1, "R7 ram0 write");
    rd(3, "R7 ram0 read");
    rd(386, "R7 ram0 over disk page");
    set_a(8'h0F, 8'hFF, "R2 ROM mode");
    wr(3, 8'h55, "R8 write dropped");
    rd(3, "R8 still boot");
    set_a(8'h2F, 8'hFF, "R2 RAM mode again");
    rd(3, "R8 ram0 untouched");

    // R10 upper half
    wr(800, 8'h3C, "R10 ram1 write");
    rd(800, "R10 ram1 read");

    // R4/R5/R6 planes
    set_a(8'h10, 8'hFF, "R4 window all planes");
    wr(520, 8'hF0, "R5 broadcast");
    set_a(8'h1E, 8'hFF, "R5 plane0 only");
    wr(520, 8'h3C, "R5 plane0 write");
    set_a(8'h10, 8'hFF, "R6 all planes");
    rd(520, "R6 merged all");
    set_a(8'h1D, 8'hFF, "R6 plane1 only");
    rd(520, "R6 plane1 untouched");
    set_a(8'h1F, 8'hFF, "R6 none");
    rd(520, "R6 empty set 0xFF");
    set_a(8'hFF, 8'h1A, "R2 masked load");
    wr(521, 8'h81, "R5 planes 0 and 2");
    set_a(8'h10, 8'hFF, "R6 all");
    wr(522, 8'h00, "R5 clear");
    rd(521, "R6 merge partial");
    rd(800, "R10 ram1 outside window");

    // R13 simultaneous read and write
    cpu_addr = AW'(800); cpu_wdata = 8'h77; cpu_wr = 1; cpu_rd = 1;
    apply("R13 rd+wr");
    rd(800, "R13 write happened");

    // Mixed traffic
    for (int i = 0; i < 600; i++) begin
      int k;
      k = $urandom % 8;
      case (k)
        0, 1, 2: rd($urandom % (1 << AW), "random read R6");
        3, 4: wr($urandom % (1 << AW), $urandom % 256, "random write R5");
        5: set_a($urandom % 256, ($urandom % 2) ? 8'hFF : ($urandom % 256), "random R2");
        6: set_b($urandom % 256, "random R3");
        default: begin
          cpu_addr = AW'($urandom % (1 << AW)); cpu_wdata = 8'($urandom);
          cpu_wr = 1; cpu_rd = 1; apply("random R13 rd+wr");
        end
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule